// File: doc/BRIEF.md
# UART Receive Status and Error Flags

This block is the receive-side status logic of a serial port. A bit-level receiver hands it each completed character together with the sampled level of the first stop bit and a raw parity-mismatch indication. It also supplies a pulse whenever a new start bit is seen. A completed character first lands in a one-entry waiting stage. From there it moves into a small receive buffer, which a data-read strobe drains in arrival order.

Software sees a 16-bit status word and writes to it through a simple write strobe. The three per-character error flags (overflow, frame error, parity error) travel with each buffered character. They therefore always describe the character that the next data read returns. The other flags are held once for the whole port: repetition limit, collision and bad sync field. Clear-to-send mirrors a pin. Dropping the receiver enable flushes the receive path and clears every receive-related flag.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the status word is 0x0000 and no character is available (`rd_valid` low).
- R2: Status bits 15..8 and bit 6 (transmitter empty) always read as 0.
- R3: Writing a 1 to bit 7, 5, 4, 2, 1 or 0 of the status word clears that flag, and writing 0 leaves it unchanged. When a hardware set and a clearing write hit the same flag in one cycle, the flag ends up set.
- R4: Bit 1 (frame error) is 1 for a character whose first stop bit was sampled as 0.
- R5: Bit 0 (parity error) is 1 only for a character received with a parity mismatch while `fmt` is 0x1, 0x5 or 0x7. Under any other format code the mismatch is ignored.
- R6: Bit 4 (bad sync) is set when a sync byte other than 0x55 is reported while `fmt` is 0x4 or 0x5 (auto-baud formats). A sync byte of 0x55, or any sync byte under another format, leaves the bit unchanged.
- R7: Bit 2 (overflow) is attached to the character in the waiting stage when a start bit is detected while the buffer is full and the waiting stage is occupied. The bit appears once that character reaches the head of the buffer.
- R8: Bits 2..0 show the flags of the head character. A data read pops the head, after which the bits show the next character's flags, or 0 when the buffer is empty. A clearing write to bits 2..0 affects only the head character.
- R9: While `rx_en` is low, the buffer and waiting stage are emptied and bits 5, 4, 2, 1, 0 are held at 0. Bit 7 is not affected by `rx_en`.
- R10: Bit 3 equals `cts_pin` when `flow_en` is 1 and reads 0 otherwise. Writes to bit 3 have no effect.
- R11: Bit 5 (collision) is set only when `coll_det` is asserted while `coll_en` is 1.
- R12: Bit 7 (repetition limit) is set by a `rep_limit` pulse.
- R13: Characters are read in arrival order. A character that completes while both the waiting stage and the buffer are full is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable |
| fmt | input | 4 | Frame format code |
| char_valid | input | 1 | Completed character strobe |
| char_data | input | DATA_W | Completed character value |
| char_stop | input | 1 | Sampled first stop bit of the character |
| char_par_err | input | 1 | Raw parity mismatch of the character |
| start_det | input | 1 | Start bit detected pulse |
| sync_valid | input | 1 | Sync byte received strobe |
| sync_byte | input | 8 | Received sync byte |
| coll_en | input | 1 | Collision detection enabled |
| coll_det | input | 1 | Collision seen on the line |
| rep_limit | input | 1 | Repetition limit reached pulse |
| flow_en | input | 1 | Flow control enabled |
| cts_pin | input | 1 | Clear-to-send pin level |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | 16 | Status write data |
| data_rd | input | 1 | Data read strobe, pops the head character |
| status | output | 16 | Status word |
| rd_data | output | DATA_W | Head character |
| rd_valid | output | 1 | Buffer holds at least one character |

## Verification
The bench uses the defaults DATA_W = 8 and DEPTH = 2. Two buffered characters plus one in the waiting stage fill the receive path in a few cycles. That makes the overflow marking, the dropped fourth character and the pointer wrap-around all reachable in a short directed sequence. The format-code table then runs each character through buffer and pop, checking the per-character flags against the parity and stop-bit rules.

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [3:0]        fmt,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_stop,
  input  logic              char_par_err,
  input  logic              start_det,
  input  logic              sync_valid,
  input  logic [7:0]        sync_byte,
  input  logic              coll_en,
  input  logic              coll_det,
  input  logic              rep_limit,
  input  logic              flow_en,
  input  logic              cts_pin,
  input  logic              reg_wr,
  input  logic [15:0]       reg_wdata,
  input  logic              data_rd,
  output logic [15:0]       status,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [2:0]        mem_f [DEPTH];
  logic [PW-1:0]     wptr, rptr;
  logic [CW-1:0]     count;
  logic              sh_vld;
  logic [DATA_W-1:0] sh_d;
  logic [2:0]        sh_f;
  logic              iter_q, coll_q, isf_q;

  wire [7:0] clr      = reg_wr ? reg_wdata[7:0] : 8'h00;
  wire       unused_w = ^{reg_wdata[15:8], clr[6], clr[3]};
  wire       full     = (count == CW'(DEPTH));
  wire       empty    = (count == '0);
  wire       push     = rx_en && sh_vld && !full;
  wire       pop      = rx_en && data_rd && !empty;
  wire       par_on   = (fmt == 4'h1) || (fmt == 4'h5) || (fmt == 4'h7);
  wire       autobaud = (fmt == 4'h4) || (fmt == 4'h5);
  wire       ovf_evt  = rx_en && start_det && full && sh_vld;
  wire       load     = rx_en && char_valid && (!sh_vld || push);
  wire       isf_set  = sync_valid && autobaud && (sync_byte != 8'h55);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iter_q <= 1'b0;
      coll_q <= 1'b0;
      isf_q  <= 1'b0;
      sh_vld <= 1'b0;
      sh_d   <= '0;
      sh_f   <= '0;
      wptr   <= '0;
      rptr   <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        mem_d[i] <= '0;
        mem_f[i] <= '0;
      end
    end else begin
      iter_q <= rep_limit | (iter_q & ~clr[7]);
      if (!rx_en) begin
        coll_q <= 1'b0;
        isf_q  <= 1'b0;
        sh_vld <= 1'b0;
        wptr   <= '0;
        rptr   <= '0;
        count  <= '0;
      end else begin
        coll_q <= (coll_en & coll_det) | (coll_q & ~clr[5]);
        isf_q  <= isf_set | (isf_q & ~clr[4]);
        if (push) begin
          mem_d[wptr] <= sh_d;
          mem_f[wptr] <= sh_f;
          wptr        <= inc(wptr);
        end
        if (pop)
          rptr <= inc(rptr);
        else if (!empty)
          mem_f[rptr] <= mem_f[rptr] & ~clr[2:0];
        count <= count + CW'(push) - CW'(pop);
        if (load) begin
          sh_vld <= 1'b1;
          sh_d   <= char_data;
          sh_f   <= {1'b0, ~char_stop, char_par_err & par_on};
        end else if (push) begin
          sh_vld <= 1'b0;
        end
        if (ovf_evt)
          sh_f[2] <= 1'b1;
      end
    end
  end

  wire [2:0] head_f = empty ? 3'b000 : mem_f[rptr];

  assign status   = {8'h00, iter_q, 1'b0, coll_q, isf_q, flow_en & cts_pin, head_f};
  assign rd_data  = mem_d[rptr];
  assign rd_valid = !empty;
endmodule

module uart_rx_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_en,
  input logic        rep_limit,
  input logic        reg_wr,
  input logic [15:0] reg_wdata,
  input logic        coll_en,
  input logic        coll_det,
  input logic        flow_en,
  input logic [15:0] status,
  input logic        rd_valid
);
  assert_iter_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rep_limit |=> status[7]);

  assert_iter_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[7] && !rep_limit) |=> !status[7]);

  assert_coll_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && coll_en && coll_det) |=> status[5]);

  assert_disable_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rd_valid && status[5:4] == 2'b00 && status[2:0] == 3'b000));

  assert_cts_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_en |-> !status[3]);
endmodule

bind uart_rx_status uart_rx_status_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rep_limit(rep_limit),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .coll_en(coll_en),
  .coll_det(coll_det), .flow_en(flow_en), .status(status), .rd_valid(rd_valid)
);

// File: tb/uart_rx_status_tb.sv
`timescale 1ns/1ps
module uart_rx_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b1;
  logic [3:0]  fmt = 4'h0;
  logic        char_valid = 1'b0;
  logic [7:0]  char_data = 8'h00;
  logic        char_stop = 1'b1;
  logic        char_par_err = 1'b0;
  logic        start_det = 1'b0;
  logic        sync_valid = 1'b0;
  logic [7:0]  sync_byte = 8'h00;
  logic        coll_en = 1'b0;
  logic        coll_det = 1'b0;
  logic        rep_limit = 1'b0;
  logic        flow_en = 1'b0;
  logic        cts_pin = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0000;
  logic        data_rd = 1'b0;
  logic [15:0] status;
  logic [7:0]  rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_rx_status #(.DATA_W(8), .DEPTH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .fmt(fmt),
    .char_valid(char_valid), .char_data(char_data), .char_stop(char_stop),
    .char_par_err(char_par_err), .start_det(start_det),
    .sync_valid(sync_valid), .sync_byte(sync_byte),
    .coll_en(coll_en), .coll_det(coll_det), .rep_limit(rep_limit),
    .flow_en(flow_en), .cts_pin(cts_pin), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .data_rd(data_rd),
    .status(status), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // {fmt, stop bit, parity mismatch, data, expected status[2:0]}
  localparam logic [16:0] VEC [7] = '{
    {4'h0, 1'b1, 1'b0, 8'hA5, 3'b000},
    {4'h0, 1'b1, 1'b1, 8'h3C, 3'b000},
    {4'h1, 1'b1, 1'b1, 8'h11, 3'b001},
    {4'h5, 1'b0, 1'b1, 8'h22, 3'b011},
    {4'h7, 1'b1, 1'b1, 8'h33, 3'b001},
    {4'h2, 1'b0, 1'b1, 8'h44, 3'b010},
    {4'h3, 1'b1, 1'b1, 8'h55, 3'b000}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic stp, input logic pe);
    char_valid = 1'b1; char_data = d; char_stop = stp; char_par_err = pe;
    tick();
    char_valid = 1'b0;
  endtask

  task automatic wr(input logic [15:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    tick();
    reg_wr = 1'b0; reg_wdata = 16'h0000;
  endtask

  task automatic rd();
    data_rd = 1'b1;
    tick();
    data_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 status", 32'(status), 32'h0);
    chk("R1 rd_valid", 32'(rd_valid), 32'h0);
    rst_n = 1'b1;
    tick();
    chk("R1 status after release", 32'(status), 32'h0);

    for (int i = 0; i < 7; i++) begin
      fmt = VEC[i][16:13];
      send(VEC[i][10:3], VEC[i][12], VEC[i][11]);
      tick();
      chk("R4/R5 head flags", 32'(status[2:0]), 32'(VEC[i][2:0]));
      chk("R13 head data", 32'(rd_data), 32'(VEC[i][10:3]));
      rd();
      chk("R8 empty after pop", 32'(rd_valid), 32'h0);
      chk("R8 flags zero when empty", 32'(status[2:0]), 32'h0);
    end
    fmt = 4'h0;

    cts_pin = 1'b1; flow_en = 1'b0;
    tick();
    chk("R10 cts gated off", 32'(status[3]), 32'h0);
    flow_en = 1'b1;
    tick();
    chk("R10 cts follows pin", 32'(status[3]), 32'h1);
    wr(16'hFF08);
    chk("R10 write ignored", 32'(status[3]), 32'h1);
    chk("R2 upper byte and bit 6", 32'({status[15:8], status[6]}), 32'h0);
    cts_pin = 1'b0;
    tick();
    chk("R10 cts low", 32'(status[3]), 32'h0);

    rep_limit = 1'b1; tick(); rep_limit = 1'b0;
    chk("R12 iter set", 32'(status[7]), 32'h1);
    wr(16'h0000);
    chk("R3 write zero keeps", 32'(status[7]), 32'h1);
    wr(16'h0080);
    chk("R3 write one clears", 32'(status[7]), 32'h0);
    rep_limit = 1'b1; wr(16'h0080); rep_limit = 1'b0;
    chk("R3 set wins", 32'(status[7]), 32'h1);

    coll_en = 1'b0; coll_det = 1'b1; tick();
    chk("R11 coll ignored when disabled", 32'(status[5]), 32'h0);
    coll_en = 1'b1; tick(); coll_det = 1'b0;
    chk("R11 coll set", 32'(status[5]), 32'h1);
    wr(16'h0020);
    chk("R3 coll cleared", 32'(status[5]), 32'h0);

    fmt = 4'h4; sync_valid = 1'b1; sync_byte = 8'h55; tick();
    chk("R6 good sync", 32'(status[4]), 32'h0);
    sync_byte = 8'h54; tick(); sync_valid = 1'b0;
    chk("R6 bad sync", 32'(status[4]), 32'h1);
    wr(16'h0010);
    chk("R3 isf cleared", 32'(status[4]), 32'h0);
    fmt = 4'h0; sync_valid = 1'b1; tick(); sync_valid = 1'b0;
    chk("R6 other format ignored", 32'(status[4]), 32'h0);

    coll_det = 1'b1; tick(); coll_det = 1'b0;
    fmt = 4'h4; sync_valid = 1'b1; tick(); sync_valid = 1'b0; fmt = 4'h0;
    send(8'h77, 1'b0, 1'b0); tick();
    chk("R9 pre-disable status", 32'(status), 32'h00B2);
    rx_en = 1'b0; tick(); rx_en = 1'b1;
    chk("R9 flushed status", 32'(status), 32'h0080);
    chk("R9 flushed buffer", 32'(rd_valid), 32'h0);
    wr(16'h0080);

    send(8'hA1, 1'b1, 1'b0); tick();
    send(8'hB2, 1'b1, 1'b0); tick();
    send(8'hC3, 1'b1, 1'b0); tick();
    send(8'hD4, 1'b1, 1'b0); tick();
    start_det = 1'b1; tick(); start_det = 1'b0;
    chk("R13 head first", 32'(rd_data), 32'hA1);
    chk("R7 head no overflow", 32'(status[2:0]), 32'h0);
    rd();
    chk("R13 second", 32'(rd_data), 32'hB2);
    rd();
    chk("R13 third", 32'(rd_data), 32'hC3);
    chk("R7 overflow on waiting char", 32'(status[2:0]), 32'h4);
    wr(16'h0004);
    chk("R8 head cleared by write", 32'(status[2:0]), 32'h0);
    rd(); tick();
    chk("R13 fourth dropped", 32'(rd_valid), 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule